// File: doc/BRIEF.md
# TDM Receive Deframer and Slot Extractor

This block takes a recovered serial bit stream and its bit clock from a time-division multiplexed link. Each frame holds 32 slots of 8 bits, sent most significant bit first, at 2.048 Mbit/s. The receive clock runs at the transmit rate but with an unknown delay. The block therefore finds the frame boundary from the data itself. It does this by looking for a programmable 8-bit marker byte, which the transmitter always places in slot 1 (the second slot).

The block has three lock states: hunting, confirming and locked. While hunting, it compares the last eight received bits against the marker on every bit. Once locked, it keeps a slot and bit position. From that position it extracts four key bits, one from each of slots 2 to 5. It also extracts two audio codec bytes, each from a slot chosen at run time by a 4-bit select. Each new codec byte comes with a one-cycle valid strobe. A lock flag shows whether the extracted data can be trusted.

Top module: `tdm_deframer`

## Requirements
- R1: A frame is 32 slots of 8 bits, received most significant bit first. Once aligned, the slot position advances every 8 bits and wraps from slot 31 to slot 0.
- R2: While hunting, the last 8 received bits (the current bit as LSB) are compared against `marker_i` on every bit. On a match, the next bit is taken as bit 0 of slot 2, whatever the bit phase before the match.
- R3: `locked_o` rises only after two frames in a row carry the marker in slot 1. The first is the hunting match. The second is the check at the end of slot 1 one frame later.
- R4: While confirming, a wrong byte in slot 1 sends the block back to hunting without setting the lock flag.
- R5: While locked, `locked_o` falls after three frames in a row with a wrong slot-1 byte. A correct slot-1 byte clears the miss count.
- R6: While locked, bit k of `keys_o` (k = 0..3) takes the LSB of slot 2+k. It updates on the clock edge that samples the last bit of that slot.
- R7: While locked, `codec_a_o` and `codec_b_o` take the byte of slot `sel_a_i`+6 and `sel_b_i`+6 respectively. The matching valid strobe is high for exactly one cycle, starting on the edge that samples the last bit of that slot.
- R8: While not locked, no valid strobe is raised and `keys_o`, `codec_a_o` and `codec_b_o` hold their values.
- R9: During and right after reset, `locked_o`, `keys_o`, both codec bytes and both strobes are 0, and the block is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ser_i | input | 1 | Received serial data, one bit per clock |
| marker_i | input | 8 | Expected marker byte for slot 1 |
| sel_a_i | input | 4 | Receive slot select for codec channel A (slot = value + 6) |
| sel_b_i | input | 4 | Receive slot select for codec channel B (slot = value + 6) |
| keys_o | output | 4 | Key bits taken from slots 2 to 5 |
| codec_a_o | output | 8 | Last byte received for codec channel A |
| codec_a_vld_o | output | 1 | One-cycle strobe: new byte on codec_a_o |
| codec_b_o | output | 8 | Last byte received for codec channel B |
| codec_b_vld_o | output | 1 | One-cycle strobe: new byte on codec_b_o |
| locked_o | output | 1 | Frame alignment is locked |

## Verification
All results are registered on the rising edge that samples the last bit of the slot that carries them. A key bit or codec byte is therefore visible one cycle after its final bit is presented, and the lock flag changes one cycle after the last marker bit. The bench drives data on falling edges and samples outputs on falling edges. It time-stamps every strobe and compares it with the frame start plus eight bit periods per slot up to and including the chosen slot. Lock state, key bits and held codec bytes are compared only at frame ends, after every slot that could change them has completed.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_CONF = 2'd1,
        ST_LOCK = 2'd2
    } lock_e;
endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
    parameter int SLOTS     = 32,
    parameter int BITS      = 8,
    parameter int SYNC_SLOT = 2,
    localparam int SW = $clog2(SLOTS),
    localparam int BW = $clog2(BITS)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          resync_i,
    output logic [SW-1:0] slot_o,
    output logic          last_bit_o
);
    typedef struct packed {
        logic [SW-1:0] slot;
        logic [BW-1:0] bitc;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (resync_i) begin
            tmr_d.slot = SW'(SYNC_SLOT);
            tmr_d.bitc = '0;
        end else if (tmr_q.bitc == BW'(BITS - 1)) begin
            tmr_d.bitc = '0;
            tmr_d.slot = (tmr_q.slot == SW'(SLOTS - 1)) ? '0 : tmr_q.slot + SW'(1);
        end else begin
            tmr_d.bitc = tmr_q.bitc + BW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign slot_o     = tmr_q.slot;
    assign last_bit_o = (tmr_q.bitc == BW'(BITS - 1));

    // R2: a hunting match puts the next bit at bit 0 of the sync slot
    assert_resync_pos_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resync_i |=> (slot_o == SW'(SYNC_SLOT) && !last_bit_o));

    // R1: the last bit of the last slot is followed by slot 0
    assert_frame_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!resync_i && last_bit_o && slot_o == SW'(SLOTS - 1)) |=> (slot_o == '0));
endmodule

// File: rtl/tdm_frame_align.sv
module tdm_frame_align
    import tdm_pkg::*;
#(
    parameter int SLOTS        = 32,
    parameter int BITS         = 8,
    parameter int MARK_SLOT    = 1,
    parameter int CONFIRM_HITS = 2,
    parameter int MISS_LIMIT   = 3,
    localparam int SW = $clog2(SLOTS),
    localparam int HW = $clog2(CONFIRM_HITS + 1),
    localparam int MW = $clog2(MISS_LIMIT + 1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ser_i,
    input  logic [BITS-1:0] marker_i,
    input  logic [SW-1:0]   slot_i,
    input  logic            last_bit_i,
    output logic [BITS-1:0] byte_o,
    output logic            resync_o,
    output logic            locked_o
);
    localparam logic [HW-1:0] HITS_N = HW'(CONFIRM_HITS);
    localparam logic [MW-1:0] MISS_N = MW'(MISS_LIMIT);

    typedef struct packed {
        lock_e          st;
        logic [HW-1:0]  hits;
        logic [MW-1:0]  miss;
        logic [BITS-2:0] sh;
    } aln_s;

    aln_s aln_d, aln_q;

    logic [BITS-1:0] byte_w;
    logic            hit;
    logic            at_mark;
    logic [HW-1:0]   hits_inc;
    logic [MW-1:0]   miss_inc;

    assign byte_w   = {aln_q.sh, ser_i};
    assign hit      = (byte_w == marker_i);
    assign at_mark  = last_bit_i && (slot_i == SW'(MARK_SLOT));
    assign hits_inc = aln_q.hits + HW'(1);
    assign miss_inc = aln_q.miss + MW'(1);

    always_comb begin
        aln_d    = aln_q;
        aln_d.sh = byte_w[BITS-2:0];
        resync_o = 1'b0;
        unique case (aln_q.st)
            ST_HUNT: begin
                if (hit) begin
                    resync_o   = 1'b1;
                    aln_d.miss = '0;
                    if (CONFIRM_HITS <= 1) begin
                        aln_d.st   = ST_LOCK;
                        aln_d.hits = '0;
                    end else begin
                        aln_d.st   = ST_CONF;
                        aln_d.hits = HW'(1);
                    end
                end
            end
            ST_CONF: begin
                if (at_mark) begin
                    if (hit) begin
                        if (hits_inc >= HITS_N) begin
                            aln_d.st   = ST_LOCK;
                            aln_d.hits = '0;
                        end else begin
                            aln_d.hits = hits_inc;
                        end
                    end else begin
                        aln_d.st   = ST_HUNT;
                        aln_d.hits = '0;
                    end
                end
            end
            ST_LOCK: begin
                if (at_mark) begin
                    if (hit) begin
                        aln_d.miss = '0;
                    end else if (miss_inc >= MISS_N) begin
                        aln_d.st   = ST_HUNT;
                        aln_d.miss = '0;
                    end else begin
                        aln_d.miss = miss_inc;
                    end
                end
            end
            default: begin
                aln_d.st = ST_HUNT;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            aln_q    <= '0;
            aln_q.st <= ST_HUNT;
        end else begin
            aln_q <= aln_d;
        end
    end

    assign byte_o   = byte_w;
    assign locked_o = (aln_q.st == ST_LOCK);

    // R3: lock is only gained on the last bit of the marker slot
    assert_lock_at_mark_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(locked_o) |-> $past(at_mark && byte_w == marker_i));

    // R5: lock is only dropped after a wrong marker slot
    assert_drop_on_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(locked_o) |-> $past(at_mark && byte_w != marker_i));

    // R2: realignment never happens while locked
    assert_no_resync_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resync_o |-> !locked_o);
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router #(
    parameter int SLOTS    = 32,
    parameter int BITS     = 8,
    parameter int NKEYS    = 4,
    parameter int KEY_SLOT = 2,
    parameter int NCH      = 2,
    parameter int SEL_W    = 4,
    parameter int SEL_BASE = 6,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  locked_i,
    input  logic                  last_bit_i,
    input  logic [SW-1:0]         slot_i,
    input  logic [BITS-1:0]       byte_i,
    input  logic [NCH*SEL_W-1:0]  sel_i,
    output logic [NKEYS-1:0]      keys_o,
    output logic [NCH*BITS-1:0]   data_o,
    output logic [NCH-1:0]        vld_o
);
    logic slot_done;
    assign slot_done = locked_i && last_bit_i;

    typedef struct packed {
        logic [NKEYS-1:0] keys;
    } key_s;

    key_s key_d, key_q;

    always_comb begin
        key_d = key_q;
        for (int k = 0; k < NKEYS; k++) begin
            if (slot_done && slot_i == SW'(KEY_SLOT + k)) key_d.keys[k] = byte_i[0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) key_q <= '0;
        else         key_q <= key_d;
    end

    assign keys_o = key_q.keys;

    // R8: key bits hold while not locked
    assert_keys_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !locked_i |=> $stable(keys_o));

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        typedef struct packed {
            logic [BITS-1:0] data;
            logic            vld;
        } chan_s;

        chan_s ch_d, ch_q;
        logic [SW-1:0] target;

        assign target = SW'(SEL_BASE) + SW'(sel_i[c*SEL_W +: SEL_W]);

        always_comb begin
            ch_d     = ch_q;
            ch_d.vld = 1'b0;
            if (slot_done && slot_i == target) begin
                ch_d.data = byte_i;
                ch_d.vld  = 1'b1;
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) ch_q <= '0;
            else         ch_q <= ch_d;
        end

        assign data_o[c*BITS +: BITS] = ch_q.data;
        assign vld_o[c]               = ch_q.vld;

        // R7: a strobe lasts exactly one cycle
        assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            vld_o[c] |=> !vld_o[c]);

        // R8: a strobe only follows a cycle spent locked
        assert_vld_needs_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            vld_o[c] |-> $past(locked_i));

        // R8: codec data holds while not locked
        assert_data_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !locked_i |=> $stable(data_o[c*BITS +: BITS]));
    end
endmodule

// File: rtl/tdm_deframer.sv
module tdm_deframer #(
    parameter int SLOTS        = 32,
    parameter int BITS         = 8,
    parameter int MARK_SLOT    = 1,
    parameter int NKEYS        = 4,
    parameter int SEL_W        = 4,
    parameter int SEL_BASE     = 6,
    parameter int CONFIRM_HITS = 2,
    parameter int MISS_LIMIT   = 3,
    localparam int KEY_SLOT = MARK_SLOT + 1,
    localparam int NCH      = 2,
    localparam int SW       = $clog2(SLOTS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ser_i,
    input  logic [BITS-1:0]  marker_i,
    input  logic [SEL_W-1:0] sel_a_i,
    input  logic [SEL_W-1:0] sel_b_i,
    output logic [NKEYS-1:0] keys_o,
    output logic [BITS-1:0]  codec_a_o,
    output logic             codec_a_vld_o,
    output logic [BITS-1:0]  codec_b_o,
    output logic             codec_b_vld_o,
    output logic             locked_o
);
    logic [SW-1:0]       slot_w;
    logic                last_bit_w;
    logic                resync_w;
    logic                locked_w;
    logic [BITS-1:0]     byte_w;
    logic [NCH*BITS-1:0] data_w;
    logic [NCH-1:0]      vld_w;

    tdm_bit_timer #(
        .SLOTS    (SLOTS),
        .BITS     (BITS),
        .SYNC_SLOT(KEY_SLOT)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .resync_i  (resync_w),
        .slot_o    (slot_w),
        .last_bit_o(last_bit_w)
    );

    tdm_frame_align #(
        .SLOTS       (SLOTS),
        .BITS        (BITS),
        .MARK_SLOT   (MARK_SLOT),
        .CONFIRM_HITS(CONFIRM_HITS),
        .MISS_LIMIT  (MISS_LIMIT)
    ) u_align (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ser_i     (ser_i),
        .marker_i  (marker_i),
        .slot_i    (slot_w),
        .last_bit_i(last_bit_w),
        .byte_o    (byte_w),
        .resync_o  (resync_w),
        .locked_o  (locked_w)
    );

    tdm_slot_router #(
        .SLOTS   (SLOTS),
        .BITS    (BITS),
        .NKEYS   (NKEYS),
        .KEY_SLOT(KEY_SLOT),
        .NCH     (NCH),
        .SEL_W   (SEL_W),
        .SEL_BASE(SEL_BASE)
    ) u_router (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .locked_i  (locked_w),
        .last_bit_i(last_bit_w),
        .slot_i    (slot_w),
        .byte_i    (byte_w),
        .sel_i     ({sel_b_i, sel_a_i}),
        .keys_o    (keys_o),
        .data_o    (data_w),
        .vld_o     (vld_w)
    );

    assign codec_a_o     = data_w[BITS-1:0];
    assign codec_b_o     = data_w[2*BITS-1:BITS];
    assign codec_a_vld_o = vld_w[0];
    assign codec_b_vld_o = vld_w[1];
    assign locked_o      = locked_w;
endmodule

// File: tb/tdm_deframer_tb.sv
`timescale 1ns/1ps
module tdm_deframer_tb;
    localparam int P = 8;
    localparam logic [7:0] MARK = 8'hA7;
    localparam int NV = 6;
    // {sel_a, sel_b, keys, byte_a, byte_b}
    localparam logic [27:0] VEC [NV] = '{
        {4'd0,  4'd1,  4'b1010, 8'h3C, 8'hC3},
        {4'd15, 4'd0,  4'b0001, 8'h5A, 8'h96},
        {4'd7,  4'd8,  4'b1111, 8'hFF, 8'h01},
        {4'd3,  4'd3,  4'b0000, 8'h77, 8'h77},
        {4'd12, 4'd2,  4'b0110, 8'h80, 8'h00},
        {4'd9,  4'd14, 4'b1001, 8'hE1, 8'h1E}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser = 1'b0;
    logic [3:0] sel_a = '0, sel_b = '0;
    logic [3:0] keys;
    logic [7:0] ca, cb;
    logic va, vb, locked;

    int n_chk = 0, n_bad = 0;
    int na = 0, nb = 0;
    logic [7:0] da, db;
    time ta, tb, t0;

    always #(P/2) clk = ~clk;

    tdm_deframer u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .marker_i(MARK),
        .sel_a_i(sel_a), .sel_b_i(sel_b), .keys_o(keys),
        .codec_a_o(ca), .codec_a_vld_o(va), .codec_b_o(cb), .codec_b_vld_o(vb),
        .locked_o(locked)
    );

    always @(negedge clk) begin
        if (va) begin na++; da = ca; ta = $time; end
        if (vb) begin nb++; db = cb; tb = $time; end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            ser = b[i];
        end
    endtask

    task automatic send_frame(input logic [7:0] mk, input logic [3:0] k,
                              input logic [7:0] a, input logic [7:0] b);
        na = 0; nb = 0;
        for (int s = 0; s < 32; s++) begin
            logic [7:0] v;
            v = 8'h00;
            if (s == 1) v = mk;
            else if (s >= 2 && s <= 5) v = {7'b0, k[s-2]};
            else if (s == int'(sel_b) + 6) v = b;
            if (s == int'(sel_a) + 6) v = a;
            if (s == 0) begin
                @(negedge clk);
                t0 = $time;
                ser = v[7];
                for (int i = 6; i >= 0; i--) begin
                    @(negedge clk);
                    ser = v[i];
                end
            end else begin
                send_byte(v);
            end
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * P);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 locked", locked, 0);
        check("R9 keys", keys, 0);
        check("R9 codec", {ca, cb}, 0);
        check("R9 vld", {va, vb}, 0);
        rst_n = 1'b1;

        // R2: odd-length idle so alignment must come from the data
        for (int i = 0; i < 21; i++) begin @(negedge clk); ser = 1'b0; end
        check("R2 idle not locked", locked, 0);

        sel_a = VEC[0][27:24]; sel_b = VEC[0][23:20];
        send_frame(MARK, VEC[0][19:16], VEC[0][15:8], VEC[0][7:0]);
        check("R3 one marker is not lock", locked, 0);
        check("R8 no strobe while confirming", na + nb, 0);
        check("R9 keys still reset", keys, 0);

        // table walk: every frame fully locked
        for (int v = 0; v < NV; v++) begin
            sel_a = VEC[v][27:24]; sel_b = VEC[v][23:20];
            send_frame(MARK, VEC[v][19:16], VEC[v][15:8], VEC[v][7:0]);
            check("R3 locked", locked, 1);
            check("R6 keys", keys, VEC[v][19:16]);
            check("R7 strobe count a", na, 1);
            check("R7 strobe count b", nb, 1);
            check("R7 codec a", da, VEC[v][15:8]);
            check("R7 codec b", db, VEC[v][7:0]);
            check("R1 R7 strobe time a", ta, t0 + time'((int'(VEC[v][27:24]) + 6) * 8 * P + 8 * P));
            check("R1 R7 strobe time b", tb, t0 + time'((int'(VEC[v][23:20]) + 6) * 8 * P + 8 * P));
        end

        // R5: misses below limit keep lock, a hit clears the count
        send_frame(8'h00, 4'b1001, 8'h42, 8'h24);
        check("R5 one miss keeps lock", locked, 1);
        send_frame(MARK, 4'b1001, 8'h42, 8'h24);
        send_frame(8'h00, 4'b1001, 8'h42, 8'h24);
        send_frame(8'h00, 4'b1001, 8'h42, 8'h24);
        check("R5 two misses after hit keep lock", locked, 1);
        check("R7 codec during misses", {ca, cb}, 16'h4224);
        send_frame(8'h00, 4'b0101, 8'h00, 8'h00);
        check("R5 third miss drops lock", locked, 0);
        check("R8 keys hold", keys, 4'b1001);
        check("R8 codec hold", {ca, cb}, 16'h4224);
        check("R8 no strobes unlocked", na + nb, 0);

        // R4: a miss while confirming returns to hunting
        send_frame(MARK, 4'b0000, 8'h00, 8'h00);
        check("R4 first marker", locked, 0);
        send_frame(8'h00, 4'b0000, 8'h00, 8'h00);
        check("R4 miss while confirming", locked, 0);
        send_frame(MARK, 4'b0000, 8'h00, 8'h00);
        check("R4 back to hunting, no lock", locked, 0);
        send_frame(MARK, 4'b0110, 8'hAB, 8'hCD);
        check("R3 relocked", locked, 1);
        check("R6 keys after relock", keys, 4'b0110);
        check("R7 codec after relock", {da, db}, 16'hABCD);

        summary();
    end
endmodule